// File: doc/BRIEF.md
# Asynchronous Timer Register Write Synchronizer

This block sits between a processor clock domain and a slow, free-running timer clock. It holds five timer registers: the counter, two compare values and two control registers. A processor write does not reach a timer register at once. It is held in a staging register dedicated to that register. The value moves into the timer register only after the timer clock has shown two rising edges. Each register has its own pending flag, which the processor can read back as a status byte. This lets software find out when a value has taken effect, for example before it lets the device sleep.

The timer clock is oversampled in the processor domain through a two-flop synchronizer followed by an edge detector. This requires the processor clock to run more than four times faster than the timer clock. When the clock-source select chooses synchronous operation, writes land in the destination on the next processor edge and no flag is ever raised. While a counter or compare write is still pending, the block tells the timer core to suppress compare matches. A second write to a register whose flag is still set is reported on a one-cycle warning pulse, because the value could be corrupted.

Top module: `atimer_wr_sync`

## Requirements
- R1: After reset, all five destination values, all staging registers, the pending flags, the warning pulses, `cnt_load` and `match_block` are zero.
- R2: With `async_sel`=1, a write to address 0 (counter), 1 (compare A), 2 (compare B), 3 (control A) or 4 (control B) stores `wdata` in that register's staging copy and sets its pending flag from the next cycle. The destination output is left unchanged.
- R3: In asynchronous mode, the destination takes the staged value on the second rising edge of `tclk` after the write, not on the first. The update appears within three processor cycles of that edge.
- R4: Bit i of `busy` (and of `rdata` when reading address 5) is the pending flag of register i, in the order counter, compare A, compare B, control A, control B. It clears in the same cycle as the destination update.
- R5: Pending transfers are independent. A counter write issued while compare B is pending neither delays nor alters the compare B transfer.
- R6: Reading address 1 to 4 returns the staging copy, which holds the last written value even while the transfer is pending.
- R7: Reading address 0 returns the live counter input `live_count`, not the staged counter value.
- R8: `match_block` is high exactly while the counter, compare A or compare B pending flag is set.
- R9: A write to a register whose pending flag is set raises that register's bit of `clash` for one cycle. The new value replaces the staged one, and the two-edge count restarts from zero.
- R10: With `async_sel`=0, a write reaches the destination on the next processor edge and the pending flags stay zero. A counter write also pulses `cnt_load` for exactly one cycle, aligned with the new `cnt_val`.
- R11: Switching `async_sel` from 1 to 0 commits every pending staged value on the next processor edge and clears its flag.
- R12: Writes to addresses 5, 6 and 7 change no register, and reads of addresses 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tclk | input | 1 | Asynchronous timer clock, oversampled |
| async_sel | input | 1 | 1: transfers wait for tclk; 0: synchronous clocking |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address (0..4 registers, 5 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| live_count | input | 8 | Running counter value from the timer core |
| cnt_val | output | 8 | Counter value to load into the timer core |
| cnt_load | output | 1 | One-cycle pulse when `cnt_val` was updated |
| cmpa_val | output | 8 | Effective compare A value |
| cmpb_val | output | 8 | Effective compare B value |
| ctla_val | output | 8 | Effective control A value |
| ctlb_val | output | 8 | Effective control B value |
| busy | output | 5 | Per-register pending flags |
| clash | output | 5 | One-cycle warning of a write to a pending register |
| match_block | output | 1 | Compare-match suppression while counter/compare writes pend |

## Verification
A stuck or miscounted edge counter shows up at the destination outputs within one timer period. A commit after the first `tclk` rise, or one missing after the second, can be seen directly on the value outputs and on `busy`. A pending flag that is lost or left set shows on `busy`, on the status read and on `match_block` in the very next cycle. Cross-talk between staging registers shows as a wrong value on a neighbouring output once its own transfer completes.

// File: rtl/atw_pkg.sv
// Package: shared sizes and the register address map of the write synchronizer.
// Assumes: five timer registers, addressed 0..4, with status at address 5.
package atw_pkg;
    localparam int NREG   = 5;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT  = 3'd0,
        A_CMPA = 3'd1,
        A_CMPB = 3'd2,
        A_CTLA = 3'd3,
        A_CTLB = 3'd4,
        A_STAT = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/atw_tclk_edge.sv
// Module: samples the asynchronous timer clock into the processor domain
// and produces a one-cycle tick for each rising edge.
// Assumes: the processor clock is more than four times the timer clock, so
// no timer edge falls between two samples unseen.
module atw_tclk_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], tclk};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // A rising edge is a new high after a low sample.
    always_comb tick = sync_q[SYNC_STAGES-1] & ~prev_q;

    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/atw_slot.sv
// Module: one timer register: a staging copy, a pending flag, a count of
// timer edges, and the destination value.
// Assumes: tick is a one-cycle pulse per timer edge; wr_hit is one cycle.
module atw_slot #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          async_sel,
    input  logic          tick,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] staged,
    output logic [DW-1:0] dest,
    output logic          busy,
    output logic          clash,
    output logic          upd
);
    logic seen_q;

    // Staging, transfer and commit of a single register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
            dest   <= '0;
            busy   <= 1'b0;
            seen_q <= 1'b0;
            clash  <= 1'b0;
            upd    <= 1'b0;
        end else begin
            upd   <= 1'b0;
            clash <= 1'b0;
            if (wr_hit) begin
                staged <= wdata;
                if (async_sel) begin
                    busy   <= 1'b1;
                    seen_q <= 1'b0;
                    clash  <= busy;
                end else begin
                    dest <= wdata;
                    busy <= 1'b0;
                    upd  <= 1'b1;
                end
            end else if (busy && !async_sel) begin
                dest <= staged;
                busy <= 1'b0;
                upd  <= 1'b1;
            end else if (busy && tick) begin
                if (seen_q) begin
                    dest   <= staged;
                    busy   <= 1'b0;
                    seen_q <= 1'b0;
                    upd    <= 1'b1;
                end else begin
                    seen_q <= 1'b1;
                end
            end
        end
    end

    a_r2_flag_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && async_sel) |=> busy);

    a_r3_dest_held_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dest));

    a_r9_clash_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> $past(busy));

    a_r10_sync_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_sel && $past(!async_sel)) |-> !busy);
endmodule

// File: rtl/atw_rd_mux.sv
// Module: read-back selection: the live counter, staging copies, or the status byte.
// Assumes: addresses follow atw_pkg; unused addresses read as zero.
module atw_rd_mux
    import atw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DW-1:0]          live_count,
    input  logic [NREG-1:0][DW-1:0] staged,
    input  logic [NREG-1:0]        busy,
    output logic [DW-1:0]          rdata
);
    // Address decode for the read port.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CNT:  rdata = live_count;
            A_CMPA: rdata = staged[1];
            A_CMPB: rdata = staged[2];
            A_CTLA: rdata = staged[3];
            A_CTLB: rdata = staged[4];
            A_STAT: rdata = DW'(busy);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/atimer_wr_sync.sv
// Module: top of the timer register write synchronizer. It decodes writes,
// runs one slot per register, and exposes the effective values and flags.
// Assumes: clk is more than four times tclk; tclk is free-running.
module atimer_wr_sync
    import atw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tclk,
    input  logic              async_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [DW-1:0]     live_count,
    output logic [DW-1:0]     cnt_val,
    output logic              cnt_load,
    output logic [DW-1:0]     cmpa_val,
    output logic [DW-1:0]     cmpb_val,
    output logic [DW-1:0]     ctla_val,
    output logic [DW-1:0]     ctlb_val,
    output logic [NREG-1:0]   busy,
    output logic [NREG-1:0]   clash,
    output logic              match_block
);
    logic                    tick;
    logic [NREG-1:0]         hit;
    logic [NREG-1:0]         upd;
    logic [NREG-1:0][DW-1:0] staged;
    logic [NREG-1:0][DW-1:0] dest;

    atw_tclk_edge #(.SYNC_STAGES(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .tclk(tclk), .tick(tick)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        // Write decode for register i.
        always_comb hit[i] = wr_en && (addr == ADDR_W'(i));

        atw_slot #(.DW(DW)) u_slot (
            .clk(clk), .rst_n(rst_n), .async_sel(async_sel), .tick(tick),
            .wr_hit(hit[i]), .wdata(wdata), .staged(staged[i]),
            .dest(dest[i]), .busy(busy[i]), .clash(clash[i]), .upd(upd[i])
        );
    end

    atw_rd_mux #(.DW(DW)) u_rd (
        .addr(addr), .live_count(live_count), .staged(staged),
        .busy(busy), .rdata(rdata)
    );

    // Route destination values to the named outputs.
    always_comb begin
        cnt_val  = dest[0];
        cmpa_val = dest[1];
        cmpb_val = dest[2];
        ctla_val = dest[3];
        ctlb_val = dest[4];
        cnt_load = upd[0];
    end

    // Suppress compare matches while counter or compare transfers pend.
    always_comb match_block = busy[0] | busy[1] | busy[2];

    a_r8_block_follows_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(match_block) |-> (upd[0] || upd[1] || upd[2]));
endmodule

// File: tb/sim_atimer_wr_sync.sv
module sim_atimer_wr_sync;
    import atw_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic rst_n, tclk, async_sel, wr_en;
    logic [2:0] addr;
    logic [7:0] wdata, rdata, live_count;
    logic [7:0] cnt_val, cmpa_val, cmpb_val, ctla_val, ctlb_val;
    logic cnt_load, match_block;
    logic [4:0] busy, clash;

    atimer_wr_sync u0 (
        .clk(clk), .rst_n(rst_n), .tclk(tclk), .async_sel(async_sel),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .live_count(live_count), .cnt_val(cnt_val), .cnt_load(cnt_load),
        .cmpa_val(cmpa_val), .cmpb_val(cmpb_val), .ctla_val(ctla_val),
        .ctlb_val(ctlb_val), .busy(busy), .clash(clash), .match_block(match_block)
    );

    typedef enum int {K_CNT, K_CMPA, K_CMPB, K_CTLA, K_CTLB, K_BUSY,
                      K_CLASH, K_RDATA, K_BLOCK, K_LOAD} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [7:0] observe(kind_e k);
        case (k)
            K_CNT:   return cnt_val;
            K_CMPA:  return cmpa_val;
            K_CMPB:  return cmpb_val;
            K_CTLA:  return ctla_val;
            K_CTLB:  return ctlb_val;
            K_BUSY:  return {3'b0, busy};
            K_CLASH: return {3'b0, clash};
            K_RDATA: return rdata;
            K_BLOCK: return {7'b0, match_block};
            default: return {7'b0, cnt_load};
        endcase
    endfunction

    // Monitor: drains expected items at the falling edge and compares.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (observe(it.kind) !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             it.tag, it.kind, observe(it.kind), it.exp);
                end
            end
        end
    end

    task automatic expect_val(kind_e k, logic [7:0] v, string tag);
        item_t it;
        it.kind = k; it.exp = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic tpulse();
        tclk = 1'b1;
        repeat (6) step();
        tclk = 1'b0;
        repeat (6) step();
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver.
    initial begin
        rst_n = 1'b0; tclk = 1'b0; async_sel = 1'b1; wr_en = 1'b0;
        addr = 3'd0; wdata = 8'h00; live_count = 8'h00;
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        expect_val(K_BUSY, 8'h00, "R1");
        expect_val(K_CMPA, 8'h00, "R1");
        expect_val(K_CNT, 8'h00, "R1");
        expect_val(K_BLOCK, 8'h00, "R1");
        expect_val(K_CLASH, 8'h00, "R1");
        settle();

        // R2 R6 R8: staged write to compare A
        wr(3'd1, 8'h5A);
        addr = 3'd1;
        expect_val(K_BUSY, 8'h02, "R2");
        expect_val(K_CMPA, 8'h00, "R2");
        expect_val(K_RDATA, 8'h5A, "R6");
        expect_val(K_BLOCK, 8'h01, "R8");
        settle();
        tpulse();
        expect_val(K_BUSY, 8'h02, "R3 one edge");
        expect_val(K_CMPA, 8'h00, "R3 one edge");
        settle();
        tpulse();
        expect_val(K_CMPA, 8'h5A, "R3 two edges");
        expect_val(K_BUSY, 8'h00, "R4");
        expect_val(K_BLOCK, 8'h00, "R8");
        settle();

        // R5: counter write during pending compare B
        wr(3'd2, 8'h33);
        tpulse();
        wr(3'd0, 8'h77);
        expect_val(K_BUSY, 8'h05, "R5");
        settle();
        tpulse();
        addr = 3'd5;
        expect_val(K_BUSY, 8'h01, "R5");
        expect_val(K_CMPB, 8'h33, "R5");
        expect_val(K_CNT, 8'h00, "R5");
        expect_val(K_RDATA, 8'h01, "R4 status");
        settle();
        tpulse();
        expect_val(K_CNT, 8'h77, "R5");
        expect_val(K_BUSY, 8'h00, "R5");
        settle();

        // R7: counter read is live
        live_count = 8'hC4; addr = 3'd0;
        expect_val(K_RDATA, 8'hC4, "R7");
        settle();

        // R6: control B read returns staged copy
        wr(3'd4, 8'h81);
        addr = 3'd4;
        expect_val(K_RDATA, 8'h81, "R6");
        expect_val(K_CTLB, 8'h00, "R6");
        settle();
        tpulse(); tpulse();
        expect_val(K_CTLB, 8'h81, "R3");
        settle();

        // R9: rewrite while pending
        wr(3'd3, 8'h11);
        tpulse();
        wr(3'd3, 8'h22);
        expect_val(K_CLASH, 8'h08, "R9");
        expect_val(K_BUSY, 8'h08, "R9");
        settle();
        step();
        expect_val(K_CLASH, 8'h00, "R9");
        settle();
        tpulse();
        expect_val(K_CTLA, 8'h00, "R9 restart");
        expect_val(K_BUSY, 8'h08, "R9 restart");
        settle();
        tpulse();
        expect_val(K_CTLA, 8'h22, "R9");
        settle();

        // R12: unused addresses
        wr(3'd6, 8'hFF);
        wr(3'd5, 8'hFF);
        addr = 3'd6;
        expect_val(K_RDATA, 8'h00, "R12");
        expect_val(K_BUSY, 8'h00, "R12");
        expect_val(K_CMPA, 8'h5A, "R12");
        expect_val(K_CTLA, 8'h22, "R12");
        settle();

        // R11: switch to synchronous with a transfer pending
        wr(3'd1, 8'h9C);
        expect_val(K_BUSY, 8'h02, "R11");
        settle();
        async_sel = 1'b0;
        step();
        expect_val(K_CMPA, 8'h9C, "R11");
        expect_val(K_BUSY, 8'h00, "R11");
        settle();

        // R10: synchronous writes
        wr(3'd0, 8'h3E);
        expect_val(K_CNT, 8'h3E, "R10");
        expect_val(K_LOAD, 8'h01, "R10");
        expect_val(K_BUSY, 8'h00, "R10");
        settle();
        step();
        expect_val(K_LOAD, 8'h00, "R10 pulse width");
        settle();
        wr(3'd3, 8'h47);
        expect_val(K_CTLA, 8'h47, "R10");
        expect_val(K_BUSY, 8'h00, "R10");
        settle();

        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule